// File: doc/BRIEF.md
# Line Input Change Interrupt Unit

This block watches the input levels of a bank of subscriber-line channels and raises an interrupt whenever one of them changes. Each channel offers five sources: two dedicated inputs that arrive already debounced, and three bidirectional pins that arrive raw. A bidirectional pin is a source only while it is configured as an input. A per-channel five-bit enable field selects which sources are recognised. Any number of them may be enabled at once.

A change in either direction on a recognised source sets that source's pending flag. The flag holds until a single global clear strobe empties every pending flag of every channel at once. A change that lands in the same cycle as the clear survives it, so no event is lost. A per-channel summary and one combined request tell the host which channels need attention. Register access and pin debouncing belong to the surrounding logic.

Top module: `lic_irq_unit`

## Requirements
- R1: A level change in either direction on a recognised source sets its pending flag at the first rising clock edge after the change.
- R2: Source numbering inside a channel's five-bit group is fixed: bit 0 and bit 1 are dedicated inputs 0 and 1, and bits 2, 3 and 4 are bidirectional pins 0, 1 and 2. Channel c occupies bits 5c to 5c+4 of the pending and enable vectors, `ded_in` bits 2c to 2c+1, and `bidir_in` and `bidir_is_out` bits 3c to 3c+2.
- R3: An enable bit of 0 ignores its source, so the pending flag does not set. An enable bit of 1 recognises it. Any combination of the five enable bits may be active together.
- R4: A bidirectional pin whose direction bit is 1 (output) never sets a pending flag. A pin whose direction bit changed at the previous clock edge is also not counted.
- R5: A pending flag stays set, without a clear, regardless of later input levels or enable changes.
- R6: A clear strobe sampled high empties the pending flags of every channel at that clock edge.
- R7: A recognised change sampled at the same edge as the clear strobe is left pending after the clear.
- R8: `ch_pend[c]` is high while channel c holds a pending flag whose enable bit is currently 1. `irq` is the OR of all `ch_pend` bits. Both follow enable changes without a clock edge.
- R9: Reset empties all pending flags. Input levels present at reset release are captured at the first clock edge and are not reported as changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ded_in | input | NUM_CH*2 | Debounced dedicated inputs |
| bidir_in | input | NUM_CH*3 | Raw levels of the bidirectional pins |
| bidir_is_out | input | NUM_CH*3 | Pin direction, 1 = output (not a source) |
| src_en | input | NUM_CH*5 | Per-source enable, 1 = recognised |
| clr_all | input | 1 | Global clear strobe for all pending flags |
| pend | output | NUM_CH*5 | Pending flag per source |
| ch_pend | output | NUM_CH | Channel has an enabled pending flag |
| irq | output | 1 | Combined interrupt request |

## Verification
A pending flag is due at the first rising edge after its input change. A clear takes effect at the edge where the strobe is sampled. `ch_pend` and `irq` follow the stored flags in the same cycle, and follow enable changes with no clock at all. The bench changes inputs on the falling edge, advances one rising edge, and reads results on the next falling edge. Enable-only effects are read a short delay after the change, with no edge in between. The reset-release and direction-switch cases are checked one and two edges after their stimulus, so a change that is wrongly counted shows up at the edge where it would appear.

// File: rtl/lic_irq_pkg.sv
// Package: constants and types shared by the line input change interrupt unit.
// Assumes five sources per channel: two dedicated inputs below three pins.
package lic_irq_pkg;
    localparam int unsigned DED_PER_CH = 2;
    localparam int unsigned BID_PER_CH = 3;
    localparam int unsigned SRC_PER_CH = DED_PER_CH + BID_PER_CH;

    typedef logic [SRC_PER_CH-1:0] src_vec_t;

    // Join a channel's dedicated and bidirectional levels into one source vector.
    function automatic src_vec_t join_src(logic [DED_PER_CH-1:0] ded,
                                          logic [BID_PER_CH-1:0] bid);
        return {bid, ded};
    endfunction
endpackage

// File: rtl/lic_src_sampler.sv
// Module: lic_src_sampler
// Registers every source level and the pin directions, and reports per-source
// changes against the previous clock. Pins driven as outputs, or whose direction
// changed at the last edge, are masked. No change is reported until one clock
// after reset release, so the levels at release are only captured.
module lic_src_sampler
    import lic_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH*DED_PER_CH-1:0] ded_in,
    input  logic [NUM_CH*BID_PER_CH-1:0] bidir_in,
    input  logic [NUM_CH*BID_PER_CH-1:0] bidir_is_out,
    output logic [NUM_CH*SRC_PER_CH-1:0] chg
);
    localparam int unsigned SRC_W = NUM_CH * SRC_PER_CH;
    localparam int unsigned BID_W = NUM_CH * BID_PER_CH;

    logic [SRC_W-1:0] now_all;
    logic [SRC_W-1:0] src_q;
    logic [BID_W-1:0] dir_q;
    logic             armed_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        src_vec_t now_v;
        src_vec_t qual_v;
        logic [BID_PER_CH-1:0] bid_ok;

        // Current levels of this channel in source order.
        assign now_v  = join_src(ded_in[c*DED_PER_CH +: DED_PER_CH],
                                 bidir_in[c*BID_PER_CH +: BID_PER_CH]);
        // A pin counts only if it was an input at this edge and the one before.
        assign bid_ok = ~(bidir_is_out[c*BID_PER_CH +: BID_PER_CH]
                        | dir_q[c*BID_PER_CH +: BID_PER_CH]);
        assign qual_v = join_src({DED_PER_CH{1'b1}}, bid_ok);
        assign now_all[c*SRC_PER_CH +: SRC_PER_CH] = now_v;
        // Qualified change against the level registered one clock earlier.
        assign chg[c*SRC_PER_CH +: SRC_PER_CH] =
            armed_q ? ((now_v ^ src_q[c*SRC_PER_CH +: SRC_PER_CH]) & qual_v) : '0;
    end

    // Keep the previous levels, the previous directions and the arming flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            dir_q   <= '1;
            armed_q <= 1'b0;
        end else begin
            src_q   <= now_all;
            dir_q   <= bidir_is_out;
            armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/lic_pend_bank.sv
// Module: lic_pend_bank
// Holds the sticky pending flag of every source. Enabled changes set flags; the
// global clear empties all channels but keeps changes seen at the same edge.
module lic_pend_bank
    import lic_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH*SRC_PER_CH-1:0] chg,
    input  logic [NUM_CH*SRC_PER_CH-1:0] src_en,
    input  logic                         clr_all,
    output logic [NUM_CH*SRC_PER_CH-1:0] pend
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        src_vec_t hit;
        src_vec_t pend_q;

        // Changes of this channel that the enable field recognises.
        assign hit = chg[c*SRC_PER_CH +: SRC_PER_CH] & src_en[c*SRC_PER_CH +: SRC_PER_CH];

        // Set on recognised change, clear all on strobe without losing new hits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= '0;
            end else if (clr_all) begin
                pend_q <= hit;
            end else begin
                pend_q <= pend_q | hit;
            end
        end

        assign pend[c*SRC_PER_CH +: SRC_PER_CH] = pend_q;
    end
endmodule

// File: rtl/lic_req_merge.sv
// Module: lic_req_merge
// Combines the stored flags with the live enable field into a per-channel
// summary and one request. Purely combinational, so enable changes act at once.
module lic_req_merge
    import lic_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input  logic [NUM_CH*SRC_PER_CH-1:0] pend,
    input  logic [NUM_CH*SRC_PER_CH-1:0] src_en,
    output logic [NUM_CH-1:0]            ch_pend,
    output logic                         irq
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Channel is flagged while one enabled source is pending.
        assign ch_pend[c] = |(pend[c*SRC_PER_CH +: SRC_PER_CH] & src_en[c*SRC_PER_CH +: SRC_PER_CH]);
    end

    // One request for the whole bank.
    assign irq = |ch_pend;
endmodule

// File: rtl/lic_irq_unit.sv
// Module: lic_irq_unit (top)
// Line input change interrupt unit for NUM_CH channels of five sources each.
// Assumes the dedicated inputs are already debounced and synchronous to clk, and
// that the bidirectional pin levels are synchronous to clk.
module lic_irq_unit
    import lic_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH*DED_PER_CH-1:0] ded_in,
    input  logic [NUM_CH*BID_PER_CH-1:0] bidir_in,
    input  logic [NUM_CH*BID_PER_CH-1:0] bidir_is_out,
    input  logic [NUM_CH*SRC_PER_CH-1:0] src_en,
    input  logic                         clr_all,
    output logic [NUM_CH*SRC_PER_CH-1:0] pend,
    output logic [NUM_CH-1:0]            ch_pend,
    output logic                         irq
);
    logic [NUM_CH*SRC_PER_CH-1:0] chg;

    lic_src_sampler #(.NUM_CH(NUM_CH)) sampler_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ded_in       (ded_in),
        .bidir_in     (bidir_in),
        .bidir_is_out (bidir_is_out),
        .chg          (chg)
    );

    lic_pend_bank #(.NUM_CH(NUM_CH)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .chg     (chg),
        .src_en  (src_en),
        .clr_all (clr_all),
        .pend    (pend)
    );

    lic_req_merge #(.NUM_CH(NUM_CH)) merge_i (
        .pend    (pend),
        .src_en  (src_en),
        .ch_pend (ch_pend),
        .irq     (irq)
    );
endmodule

// File: rtl/lic_irq_unit_chk.sv
// Module: lic_irq_unit_chk
// Property checker for lic_irq_unit, attached by bind. Observes ports only.
module lic_irq_unit_chk
    import lic_irq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH*DED_PER_CH-1:0] ded_in,
    input logic [NUM_CH*BID_PER_CH-1:0] bidir_is_out,
    input logic [NUM_CH*SRC_PER_CH-1:0] src_en,
    input logic                         clr_all,
    input logic [NUM_CH*SRC_PER_CH-1:0] pend,
    input logic [NUM_CH-1:0]            ch_pend,
    input logic                         irq
);
    logic                         seen_q;
    logic [NUM_CH*SRC_PER_CH-1:0] out_pos;

    // Marks that one clock has passed since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_pos
        assign out_pos[c*SRC_PER_CH +: SRC_PER_CH] =
            join_src('0, bidir_is_out[c*BID_PER_CH +: BID_PER_CH]);
    end

    for (genvar i = 0; i < NUM_CH*DED_PER_CH; i++) begin : g_ded
        localparam int unsigned P = (i / DED_PER_CH) * SRC_PER_CH + (i % DED_PER_CH);
        AST_DED_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (seen_q && (ded_in[i] != $past(ded_in[i])) && src_en[P]) |=> pend[P]); // R1
    end

    AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(src_en)) == '0)); // R3

    AST_OUTPUT_PIN_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & $past(out_pos)) == '0)); // R4

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> ((pend & $past(pend)) == $past(pend))); // R5

    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && seen_q && ded_in == $past(ded_in) && $stable(bidir_is_out)
         && bidir_is_out == '1) |=> (pend == '0)); // R6

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend != '0 && ch_pend != '0)); // R8
endmodule

bind lic_irq_unit lic_irq_unit_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ded_in       (ded_in),
    .bidir_is_out (bidir_is_out),
    .src_en       (src_en),
    .clr_all      (clr_all),
    .pend         (pend),
    .ch_pend      (ch_pend),
    .irq          (irq)
);

// File: tb/lic_irq_unit_tb_top.sv
// Bench for lic_irq_unit: sweeps every source, every enable pattern and the
// clear and direction corner cases, with expected values computed here.
module lic_irq_unit_tb_top;
    localparam int NCH   = 4;
    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*2-1:0]  ded = '1;
    logic [NCH*3-1:0]  bid = '0;
    logic [NCH*3-1:0]  bdir = '0;
    logic [NCH*5-1:0]  en = '1;
    logic              clr = 1'b0;
    logic [NCH*5-1:0]  pend;
    logic [NCH-1:0]    ch_pend;
    logic              irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lic_irq_unit #(.NUM_CH(NCH)) dut_i (
        .clk (clk), .rst_n (rst_n), .ded_in (ded), .bidir_in (bid),
        .bidir_is_out (bdir), .src_en (en), .clr_all (clr),
        .pend (pend), .ch_pend (ch_pend), .irq (irq)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        clr = 1'b1;
        step();
        clr = 1'b0;
    endtask

    task automatic flip(int ch, int s);
        if (s < 2) ded[ch*2 + s] = ~ded[ch*2 + s];
        else       bid[ch*3 + s - 2] = ~bid[ch*3 + s - 2];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R9: reset state with inputs held high through reset release
        repeat (3) step();
        check("R9 pend in reset", 32'(pend), 32'h0);
        rst_n = 1'b1;
        step();
        step();
        check("R9 no event at release", 32'(pend), 32'h0);
        check("R9 irq idle", 32'(irq), 32'h0);

        // R1: falling edges on all dedicated inputs
        ded = '0;
        step();
        check("R1 falling dedicated", 32'(pend), 32'h0018C63);
        clear_all();
        check("R6 clear", 32'(pend), 32'h0);

        // R1 R2: each single source, both directions
        for (int ch = 0; ch < NCH; ch++) begin
            for (int s = 0; s < 5; s++) begin
                for (int dirn = 0; dirn < 2; dirn++) begin
                    flip(ch, s);
                    step();
                    check("R2 single source", 32'(pend), 32'(1) << (ch*5 + s));
                    check("R8 channel summary", 32'(ch_pend), 32'(1) << ch);
                    check("R8 irq", 32'(irq), 32'h1);
                    step();
                    check("R5 held", 32'(pend), 32'(1) << (ch*5 + s));
                    clear_all();
                    check("R6 cleared", 32'(pend), 32'h0);
                end
            end
        end

        // R3: every enable pattern, channels offset from each other
        for (int m = 0; m < 32; m++) begin
            logic [31:0] exp;
            exp = '0;
            for (int ch = 0; ch < NCH; ch++) begin
                en[ch*5 +: 5] = 5'((m + ch*7) & 31);
                exp |= 32'((m + ch*7) & 31) << (ch*5);
                for (int s = 0; s < 5; s++) flip(ch, s);
            end
            step();
            check("R3 enable pattern", 32'(pend), exp);
            clear_all();
        end
        en = '1;
        step();

        // R4: pins as outputs never report
        bdir = '1;
        step();
        bid = ~bid;
        step();
        check("R4 output pins", 32'(pend), 32'h0);
        // R4: direction switching in the same cycle as a level change
        bdir = '0;
        bid = ~bid;
        step();
        check("R4 direction switch", 32'(pend), 32'h0);
        step();
        check("R4 after switch", 32'(pend), 32'h0);
        bid = ~bid;
        step();
        check("R4 inputs again", 32'(pend), 32'hE739C);
        clear_all();

        // R5: sticky across idle cycles and accumulation
        flip(1, 0);
        step();
        repeat (3) step();
        check("R5 sticky", 32'(pend), 32'h20);
        flip(2, 3);
        step();
        check("R5 accumulate", 32'(pend), 32'h2020);

        // R7: change in the clear cycle survives
        clr = 1'b1;
        flip(3, 4);
        step();
        clr = 1'b0;
        check("R7 kept through clear", 32'(pend), 32'h80000);

        // R8: enable masks the summary without a clock
        en[3*5 + 4] = 1'b0;
        #1;
        check("R8 masked summary", 32'(ch_pend), 32'h0);
        check("R8 masked irq", 32'(irq), 32'h0);
        check("R5 flag kept when masked", 32'(pend), 32'h80000);
        en[3*5 + 4] = 1'b1;
        #1;
        check("R8 unmasked summary", 32'(ch_pend), 32'h8);
        check("R8 unmasked irq", 32'(irq), 32'h1);

        // R3: disabled source ignored while others still set
        @(negedge clk);
        clear_all();
        en[0] = 1'b0;
        flip(0, 0);
        flip(0, 1);
        step();
        check("R3 disabled ignored", 32'(pend), 32'h2);
        en = '1;

        // R9: reset empties flags
        rst_n = 1'b0;
        step();
        check("R9 reset clears", 32'(pend), 32'h0);
        rst_n = 1'b1;
        step();
        check("R9 irq after reset", 32'(irq), 32'h0);

        finish_run();
    end
endmodule